// File: doc/BRIEF.md
# Voted Branch Clock Gate

This block gates one derived clock branch. Software asks for the clock in one of two ways. It can set a direct enable bit in the branch control word, or it can set any bit in a shared vote word that holds one bit per voter. The effective request is the OR of the direct bit and every vote bit. That request passes through a short synchronizer before the branch is treated as running. The gated clock-enable output is the incoming clock-enable ANDed with the synchronized request.

Software polls the top four bits of the control word to learn whether the branch is really running. The top bit is a read-only off flag, and it clears only after the synchronizer delay. A static strap picks the code that a running branch reports. One code means plain on. The other means on while an interconnect state machine is in control.

The running state is held in a two-state machine. The states are `ST_OFF` and `ST_ON`. The transition named arm moves `ST_OFF` to `ST_ON` when the synchronized request is high. The transition named release moves `ST_ON` to `ST_OFF` when the synchronized request is low. In every other case each state holds.

Top module: `clkbr_gate`

## Requirements
- R1: After reset, the control word reads 0x8000_0000, the vote word reads 0, the status port reads 4'b1000 and `clk_en_out` is 0.
- R2: A write with `reg_sel`=0 stores `reg_wdata[0]` as the direct enable. The direct enable reads back at bit 0 of the control word.
- R3: A write with `reg_sel`=1 stores `reg_wdata[NUM_VOTERS-1:0]` as the vote bits, and they read back at the same positions. Vote-word bits at and above NUM_VOTERS read 0 and ignore writes.
- R4: Control-word bits 31:1 are read-only. Writing any value to them changes neither the control word nor the vote word.
- R5: The effective request is the direct enable OR any vote bit. With direct enable 0, any single vote bit alone turns the branch on.
- R6: A request that rises at write edge k shows as running at edge k+2. At edges k and k+1 the status still reports off.
- R7: A request that falls at write edge k shows as off at edge k+2. At edges k and k+1 the status still reports running.
- R8: Status field bits 31:28 of the control word, also driven on `branch_code`, read 4'b1000 when off. When running they read 4'b0000 with `fsm_mode`=0 and 4'b0010 with `fsm_mode`=1. Bit 31 is the off flag.
- R9: `clk_en_out` equals `clk_en_in` AND the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control word, 1 vote word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| fsm_mode | input | 1 | Strap: running branch reports the interconnect-controlled code |
| clk_en_in | input | 1 | Incoming clock-enable |
| clk_en_out | output | 1 | Gated clock-enable |
| branch_code | output | 4 | Status field, same as control bits 31:28 |

## Verification
Two functions can fall in the same cycle: a new request entering the synchronizer and an older request arriving at the state machine. The bench provokes this by writing enable at one edge and clearing it at the very next edge. The on code must then appear for exactly one sampled cycle, two edges after the set, and the off code must return one edge later. Sampling at each half cycle in between judges whether both edges of the pulse kept their two-cycle lag.

// File: rtl/clkbr_pkg.sv
package clkbr_pkg;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_ON  = 1'b1
    } br_state_e;

    localparam logic [3:0] CODE_OFF    = 4'b1000;
    localparam logic [3:0] CODE_ON     = 4'b0000;
    localparam logic [3:0] CODE_ON_FSM = 4'b0010;

    localparam int CODE_W = 4;

endpackage

// File: rtl/clkbr_regs.sv
module clkbr_regs
    import clkbr_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int NUM_VOTERS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              en_o,
    output logic [NUM_VOTERS-1:0] votes_o
);

    localparam int CODE_LSB = DATA_W - CODE_W;

    logic                  en_q;
    logic [NUM_VOTERS-1:0] votes_q;
    logic                  unused_wdata;

    assign unused_wdata = ^wdata_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            votes_q <= '0;
        end else if (wr_i) begin
            if (!sel_i) en_q    <= wdata_i[0];
            else        votes_q <= wdata_i[NUM_VOTERS-1:0];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (!sel_i) begin
            rdata_o[0]                       = en_q;
            rdata_o[DATA_W-1:CODE_LSB]       = code_i;
        end else begin
            rdata_o[NUM_VOTERS-1:0]          = votes_q;
        end
    end

    assign en_o    = en_q;
    assign votes_o = votes_q;

    p_en_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !sel_i) |=> (en_o == $past(wdata_i[0])));

    p_vote_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && sel_i) |=> $stable(votes_o));

endmodule

// File: rtl/clkbr_sync.sv
module clkbr_sync #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q_o = d_i;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2+((STAGES>1)?0:1):0], d_i};
            end
            assign q_o = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/clkbr_status_fsm.sv
module clkbr_status_fsm
    import clkbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              fsm_mode_i,
    output logic              running_o,
    output logic [CODE_W-1:0] code_o
);

    br_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (req_i)  state_d = ST_ON;
            ST_ON:  if (!req_i) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        running_o = 1'b0;
        code_o    = CODE_OFF;
        unique case (state_q)
            ST_OFF: begin
                running_o = 1'b0;
                code_o    = CODE_OFF;
            end
            ST_ON: begin
                running_o = 1'b1;
                code_o    = fsm_mode_i ? CODE_ON_FSM : CODE_ON;
            end
            default: begin
                running_o = 1'b0;
                code_o    = CODE_OFF;
            end
        endcase
    end

    p_code_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(code_o));

endmodule

// File: rtl/clkbr_gate.sv
module clkbr_gate
    import clkbr_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int NUM_VOTERS  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              fsm_mode,
    input  logic              clk_en_in,
    output logic              clk_en_out,
    output logic [3:0]        branch_code
);

    localparam int CHAIN = SYNC_STAGES - 1;

    logic                  en_w;
    logic [NUM_VOTERS-1:0] votes_w;
    logic                  eff_req;
    logic                  req_sync;
    logic                  running;
    logic [CODE_W-1:0]     code_w;

    clkbr_regs #(
        .DATA_W     (DATA_W),
        .NUM_VOTERS (NUM_VOTERS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .sel_i   (reg_sel),
        .wdata_i (reg_wdata),
        .code_i  (code_w),
        .rdata_o (reg_rdata),
        .en_o    (en_w),
        .votes_o (votes_w)
    );

    assign eff_req = en_w | (|votes_w);

    clkbr_sync #(
        .STAGES (CHAIN)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (eff_req),
        .q_o   (req_sync)
    );

    clkbr_status_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_sync),
        .fsm_mode_i (fsm_mode),
        .running_o  (running),
        .code_o     (code_w)
    );

    assign clk_en_out  = clk_en_in & running;
    assign branch_code = code_w;

    p_on_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eff_req |-> ##SYNC_STAGES running);

    p_off_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !eff_req |-> ##SYNC_STAGES !running);

    p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_out |-> (clk_en_in && branch_code[3] == 1'b0));

    p_vote_or_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|votes_w) |-> ##SYNC_STAGES !branch_code[3]);

endmodule

// File: tb/test_clkbr_gate.sv
module test_clkbr_gate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fsm_mode = 1'b0;
    logic        clk_en_in = 1'b0;
    logic        clk_en_out;
    logic [3:0]  branch_code;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    clkbr_gate i_clkbr_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .fsm_mode    (fsm_mode),
        .clk_en_in   (clk_en_in),
        .clk_en_out  (clk_en_out),
        .branch_code (branch_code)
    );

    typedef struct packed {
        logic        sel;
        logic [31:0] data;
        logic        mode;
        logic        cen;
        logic [31:0] ctl;
        logic [31:0] vote;
        logic        out;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0000_0001, 1'b0, 1'b1, 32'h0000_0001, 32'h0000_0000, 1'b1},
        '{1'b0, 32'hFFFF_FFFE, 1'b0, 1'b1, 32'h8000_0000, 32'h0000_0000, 1'b0},
        '{1'b1, 32'h0000_0004, 1'b1, 1'b1, 32'h2000_0000, 32'h0000_0004, 1'b1},
        '{1'b1, 32'hFFFF_FF00, 1'b1, 1'b1, 32'h8000_0000, 32'h0000_0000, 1'b0},
        '{1'b1, 32'h0000_0080, 1'b1, 1'b0, 32'h2000_0000, 32'h0000_0080, 1'b0},
        '{1'b0, 32'h0000_0001, 1'b0, 1'b1, 32'h0000_0001, 32'h0000_0080, 1'b1},
        '{1'b1, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0001, 32'h0000_0000, 1'b1},
        '{1'b0, 32'h0000_0000, 1'b0, 1'b1, 32'h8000_0000, 32'h0000_0000, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_wr(input logic sel, input logic [31:0] data);
        reg_wr    = 1'b1;
        reg_sel   = sel;
        reg_wdata = data;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic read_word(input logic sel, output logic [31:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;

        repeat (3) @(negedge clk);
        read_word(1'b0, v);
        check("R1 ctl in reset", v, 32'h8000_0000);
        rst_n = 1'b1;
        @(negedge clk);
        read_word(1'b0, v);
        check("R1 ctl after reset", v, 32'h8000_0000);
        read_word(1'b1, v);
        check("R1 vote after reset", v, 32'h0);
        check("R1 code after reset", {28'h0, branch_code}, 32'h8);
        clk_en_in = 1'b1;
        #1;
        check("R1 gated out after reset", {31'h0, clk_en_out}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            fsm_mode  = VECS[i].mode;
            clk_en_in = VECS[i].cen;
            drive_wr(VECS[i].sel, VECS[i].data);
            idle();
            @(negedge clk);
            @(negedge clk);
            read_word(1'b0, v);
            check("R2 R4 R5 R8 ctl word", v, VECS[i].ctl);
            read_word(1'b1, v);
            check("R3 vote word", v, VECS[i].vote);
            check("R9 gated out", {31'h0, clk_en_out}, {31'h0, VECS[i].out});
        end

        fsm_mode  = 1'b0;
        clk_en_in = 1'b1;
        drive_wr(1'b0, 32'h1);
        idle();
        check("R6 edge k", {28'h0, branch_code}, 32'h8);
        @(negedge clk);
        check("R6 edge k+1", {28'h0, branch_code}, 32'h8);
        @(negedge clk);
        check("R6 edge k+2", {28'h0, branch_code}, 32'h0);

        drive_wr(1'b0, 32'h0);
        idle();
        check("R7 edge k", {28'h0, branch_code}, 32'h0);
        @(negedge clk);
        check("R7 edge k+1", {28'h0, branch_code}, 32'h0);
        @(negedge clk);
        check("R7 edge k+2", {28'h0, branch_code}, 32'h8);

        fsm_mode = 1'b1;
        drive_wr(1'b0, 32'h1);
        drive_wr(1'b0, 32'h0);
        idle();
        check("R6 pulse k+1", {28'h0, branch_code}, 32'h8);
        @(negedge clk);
        check("R6 R8 pulse k+2", {28'h0, branch_code}, 32'h2);
        check("R9 pulse out", {31'h0, clk_en_out}, 32'h1);
        @(negedge clk);
        check("R7 pulse k+3", {28'h0, branch_code}, 32'h8);

        drive_wr(1'b1, 32'h0000_0001);
        idle();
        repeat (2) @(negedge clk);
        fsm_mode = 1'b0;
        #1;
        check("R5 R8 vote0 strap0", {28'h0, branch_code}, 32'h0);
        drive_wr(1'b0, 32'h7FFF_FFFE);
        idle();
        read_word(1'b1, v);
        check("R4 vote untouched", v, 32'h1);
        read_word(1'b0, v);
        check("R4 ctl untouched", v, 32'h0);

        finish_run();
    end

endmodule